// File: doc/BRIEF.md
# Memory-card socket status and interrupt register block

This block sits on a simple 32-bit register bus and lets software identify the board and watch a memory-card socket. It reports a fixed identification word, a fixed decode setting, and a status register that combines two things. The first is the live level of the socket's write-protect switch. The second is a sticky flag that records that a card was inserted. The sticky flag drives a single interrupt line. Software clears it by writing a 1 to its bit position.

The bus has no back-pressure. A select with write high is taken in the cycle it appears, and read data is a combinational function of the word index. The socket inputs are plain levels, and the interrupt is a plain registered level.

Top module: `card_socket_ctrl`

## Requirements
- R1: Word index 0 reads the constant identification value 0x41034003.
- R2: Word index 1 reads 0x00000000 and word index 3 reads 0x00000011.
- R3: Writes to indices 0, 1 and 3 are accepted and leave every readable value unchanged.
- R4: Bit 0 of the status word at index 2 equals the current `sock_wp_i` level, in both directions, with no clock delay.
- R5: When `sock_cd_i` is high at a clock edge, bit 3 of the status word and `card_irq_o` are 1 from that edge onward. A low level on `sock_cd_i` never clears them.
- R6: A write to index 2 whose data has bit 3 set clears bit 3 at that edge. Writes to index 2 with bit 3 clear leave it unchanged, whatever the other data bits hold.
- R7: If `sock_cd_i` is high at the same edge as a clearing write, bit 3 stays 1.
- R8: `card_irq_o` always equals the stored bit 3 of the status word.
- R9: After reset, bit 3 and `card_irq_o` are 0. Status bits other than 0 and 3 always read 0.
- R10: Word indices 4 and above read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write when selected |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sock_wp_i | input | 1 | Write-protect switch level |
| sock_cd_i | input | 1 | Card-insert level |
| card_irq_o | output | 1 | Card-insert interrupt |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the same edge as a still-high insert level. That collision must leave the flag set. The stimulus holds `sock_cd_i` high and issues the clearing write in the same cycle. It then drops the level and clears again, to show that the second clear does take effect. The stimulus also sends a write of all ones except bit 3, to show that only bit 3 clears the flag.

// File: rtl/cdreg_pkg.sv
package cdreg_pkg;
  localparam int IDX_ID     = 0;
  localparam int IDX_FLASH  = 1;
  localparam int IDX_STAT   = 2;
  localparam int IDX_DECODE = 3;
  localparam int BIT_WP     = 0;
  localparam int BIT_CARD   = 3;
endpackage

// File: rtl/cdreg_wr_decode.sv
module cdreg_wr_decode #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              clr_o
);
  import cdreg_pkg::*;
  localparam logic [DATA_W-1:0] CARD_MASK = DATA_W'(1) << BIT_CARD;
  logic [DATA_W-1:0] hit;

  // Only the card bit of the data matters; other bits are masked away.
  assign hit   = wdata_i & CARD_MASK;
  assign clr_o = sel_i && wr_i && (addr_i == ADDR_W'(IDX_STAT)) && (|hit);
endmodule

// File: rtl/cdreg_card_latch.sv
module cdreg_card_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic insert_i,
  input  logic clr_i,
  output logic pend_o
);
  // Set has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_o <= 1'b0;
    else if (insert_i) pend_o <= 1'b1;
    else if (clr_i)    pend_o <= 1'b0;
  end
endmodule

// File: rtl/cdreg_readmux.sv
module cdreg_readmux #(
  parameter int                 DATA_W       = 32,
  parameter int                 ADDR_W       = 4,
  parameter logic [DATA_W-1:0]  ID_VALUE     = 32'h4103_4003,
  parameter logic [DATA_W-1:0]  DECODE_VALUE = 32'h0000_0011
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  input  logic              pend_i,
  output logic [DATA_W-1:0] rdata_o
);
  import cdreg_pkg::*;
  logic [DATA_W-1:0] status;

  always_comb begin
    status           = '0;
    status[BIT_WP]   = wp_i;
    status[BIT_CARD] = pend_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(IDX_ID):     rdata_o = ID_VALUE;
      ADDR_W'(IDX_FLASH):  rdata_o = '0;
      ADDR_W'(IDX_STAT):   rdata_o = status;
      ADDR_W'(IDX_DECODE): rdata_o = DECODE_VALUE;
      default:             rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/card_socket_ctrl.sv
module card_socket_ctrl #(
  parameter int                DATA_W       = 32,
  parameter int                ADDR_W       = 4,
  parameter logic [DATA_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sock_wp_i,
  input  logic              sock_cd_i,
  output logic              card_irq_o
);
  logic clr;
  logic pend;

  cdreg_wr_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .clr_o(clr)
  );

  cdreg_card_latch u_latch (
    .clk(clk), .rst_n(rst_n), .insert_i(sock_cd_i),
    .clr_i(clr), .pend_o(pend)
  );

  cdreg_readmux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ID_VALUE(ID_VALUE), .DECODE_VALUE(DECODE_VALUE)
  ) u_rd (
    .addr_i(bus_addr), .wp_i(sock_wp_i), .pend_i(pend), .rdata_o(bus_rdata)
  );

  assign card_irq_o = pend;
endmodule

// File: rtl/cdreg_chk.sv
module cdreg_chk #(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 4,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h4103_4003
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sock_wp_i,
  input logic              sock_cd_i,
  input logic              card_irq_o
);
  logic clr_wr;
  assign clr_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(2)) && bus_wdata[3];

  a_r5_set_on_insert: assert property (@(posedge clk) disable iff (!rst_n)
    sock_cd_i |=> card_irq_o);
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sock_cd_i && clr_wr) |=> card_irq_o);
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !sock_cd_i) |=> !card_irq_o);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (card_irq_o && !clr_wr) |=> card_irq_o);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_irq_o && !sock_cd_i) |=> !card_irq_o);
  a_r4_wp_live: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(2)) |-> (bus_rdata[0] == sock_wp_i && bus_rdata[3] == card_irq_o));
  a_r1_id: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata == ID_VALUE));
endmodule

bind card_socket_ctrl cdreg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .sock_wp_i(sock_wp_i), .sock_cd_i(sock_cd_i), .card_irq_o(card_irq_o)
);

// File: tb/sim_card_socket_ctrl.sv
`timescale 1ns/1ps
module sim_card_socket_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sock_wp_i = 1'b0, sock_cd_i = 1'b0;
  logic        card_irq_o;

  int n_tests = 0, n_fail = 0;
  bit card_m = 1'b0;   // reference sticky flag

  always #2.5 clk = ~clk;

  card_socket_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sock_wp_i(sock_wp_i), .sock_cd_i(sock_cd_i), .card_irq_o(card_irq_o)
  );

  function automatic logic [31:0] model_read(int a, bit wp, bit card);
    case (a)
      0: return 32'h4103_4003;          // R1
      1: return 32'h0;                  // R2
      2: return {28'h0, card, 2'b00, wp}; // R4 R9
      3: return 32'h0000_0011;          // R2
      default: return 32'h0;            // R10
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive inputs after a falling edge, compare against model, then advance one clock.
  task automatic step(bit s, bit w, int a, logic [31:0] d, bit wp, bit cd, string req);
    bus_sel = s; bus_wr = w; bus_addr = a[3:0]; bus_wdata = d;
    sock_wp_i = wp; sock_cd_i = cd;
    #1;
    check({req, " rdata"}, bus_rdata, model_read(a, wp, card_m));
    check({req, " irq R8"}, {31'h0, card_irq_o}, {31'h0, card_m});
    @(posedge clk);
    if (rst_n) begin
      if (cd) card_m = 1'b1;
      else if (s && w && a == 2 && d[3]) card_m = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(0, 0, 2, 0, 0, 1, "R9 reset");   // insert ignored during reset
    check("R9 reset irq", {31'h0, card_irq_o}, 32'h0);
    rst_n = 1'b1;
    step(0, 0, 2, 0, 0, 0, "R9 after reset");
    step(0, 0, 0, 0, 0, 0, "R1 id");
    step(0, 0, 1, 0, 0, 0, "R2 idx1");
    step(0, 0, 3, 0, 0, 0, "R2 idx3");
    step(0, 0, 7, 0, 0, 0, "R10 idx7");
    step(0, 0, 15, 0, 0, 0, "R10 idx15");
    // R3 writes ignored
    step(1, 1, 0, 32'hFFFF_FFFF, 0, 0, "R3 wr0");
    step(1, 1, 1, 32'hFFFF_FFFF, 0, 0, "R3 wr1");
    step(1, 1, 3, 32'hFFFF_FFFF, 0, 0, "R3 wr3");
    step(1, 1, 9, 32'hFFFF_FFFF, 0, 0, "R10 wr9");
    step(0, 0, 0, 0, 0, 0, "R3 reread0");
    step(0, 0, 1, 0, 0, 0, "R3 reread1");
    step(0, 0, 3, 0, 0, 0, "R3 reread3");
    step(0, 0, 9, 0, 0, 0, "R10 reread9");
    // R4 live write-protect
    step(0, 0, 2, 0, 1, 0, "R4 wp high");
    step(0, 0, 2, 0, 0, 0, "R4 wp low");
    step(1, 1, 2, 32'h0000_0001, 1, 0, "R4 wp with write");
    // R5 insert sets sticky flag
    step(0, 0, 2, 0, 0, 1, "R5 insert");
    step(0, 0, 2, 0, 0, 0, "R5 sticky");
    step(0, 0, 2, 0, 1, 0, "R5 sticky wp");
    // R6 only bit 3 clears
    step(1, 1, 2, 32'hFFFF_FFF7, 0, 0, "R6 other bits");
    step(0, 0, 2, 0, 0, 0, "R6 still set");
    step(1, 0, 2, 32'h8, 0, 0, "R6 read no clear");
    step(1, 1, 3, 32'h8, 0, 0, "R6 wrong index");
    step(1, 1, 2, 32'h8, 0, 0, "R6 clear");
    step(0, 0, 2, 0, 0, 0, "R6 cleared");
    // R7 set wins against clear
    step(0, 0, 2, 0, 0, 1, "R7 insert");
    step(1, 1, 2, 32'h8, 0, 1, "R7 clear during insert");
    step(0, 0, 2, 0, 0, 0, "R7 still set");
    step(1, 1, 2, 32'h8, 1, 0, "R7 clear after drop");
    step(0, 0, 2, 0, 1, 0, "R7 cleared");
    step(0, 0, 5, 0, 1, 1, "R10 idx5 during insert");
    step(0, 0, 2, 0, 0, 0, "R5 set seen");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule